// File: doc/BRIEF.md
# Coded Correction Stage for Four Parallel FFT Channels

This block surrounds four identical streaming FFT channels with a linear code that locates and repairs a single faulty channel. On the input side, an encoder forms three extra input streams, each the sum of a fixed group of three original inputs. Three extra FFT channels, outside this block, transform these streams. On the output side, three checks compare each extra FFT output against the sum of the original FFT outputs in its group. These checks work because the transform is linear. The three check results form a syndrome that names the faulty channel.

When the syndrome names one of the four original channels, that channel's output is replaced. The replacement is rebuilt from one extra output minus the healthy members of its group. When the syndrome names an extra channel, the original outputs pass through unchanged and only the location is reported. Every sample is complex, and a check fires if the real or the imaginary difference exceeds a threshold set at a port. The block handles one faulty channel at a time.

The original channels carry 12-bit inputs and produce 14-bit outputs. The extra channels use 14-bit inputs and 16-bit outputs so that the group sums cannot overflow. Original channels are numbered 1 to 4 and extra channels 5 to 7. Inside a flat bus, channel n sits in slice n-1 (or n-5 for the extra channels), with slice 0 at the least significant bits.

Top module: `hfg_guard`

## Requirements
- R1: The encoder outputs are combinational and sign-extended to 14 bits, for both real and imaginary parts: extra input 5 = x1+x2+x3, extra input 6 = x1+x2+x4, extra input 7 = x1+x3+x4.
- R2: Check bit Ck (k = 1, 2, 3) is set when the absolute value of (extra output k+4 minus the sum of its group's original outputs) is strictly greater than `thr` on the real part or on the imaginary part. A difference equal to `thr` does not set the bit. The groups are the same as in R1.
- R3: `err_loc` is the channel number decoded from the code C1 C2 C3 (C1 first): 000→0 (no error), 111→1, 110→2, 101→3, 011→4, 100→5, 010→6, 001→7.
- R4: When the location is 1, 2 or 3, that channel's output is replaced by extra output 5 minus the other two outputs of the group {1,2,3}, taken modulo 2^14.
- R5: When the location is 4, channel 4's output is replaced by extra output 6 minus outputs 1 and 2, taken modulo 2^14.
- R6: When the location is 5, 6 or 7, all four corrected outputs equal the incoming original outputs.
- R7: When no check fires, the corrected outputs equal the incoming outputs and `err_loc` is 0.
- R8: `out_valid`, the corrected outputs and `err_loc` appear one clock after the sample they belong to. `out_valid` equals the previous cycle's `in_valid`, and `err_loc` is 0 whenever `out_valid` is 0.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `err_loc` and all corrected outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_re | input | 48 | Real parts of the four original input samples |
| x_im | input | 48 | Imaginary parts of the four original input samples |
| enc_re | output | 42 | Real parts of the three extra input samples |
| enc_im | output | 42 | Imaginary parts of the three extra input samples |
| in_valid | input | 1 | A set of FFT output samples is present |
| y_re | input | 56 | Real parts of the four original FFT outputs |
| y_im | input | 56 | Imaginary parts of the four original FFT outputs |
| r_re | input | 48 | Real parts of the three extra FFT outputs |
| r_im | input | 48 | Imaginary parts of the three extra FFT outputs |
| thr | input | 16 | Unsigned detection threshold |
| out_valid | output | 1 | Corrected sample valid |
| z_re | output | 56 | Real parts of the corrected outputs |
| z_im | output | 56 | Imaginary parts of the corrected outputs |
| err_loc | output | 3 | Faulty channel number, 0 when none |

## Verification
The hardest cases to reach from the ports are faults that land exactly on the threshold, and faults that show up only in the imaginary part. At those points a one-off comparison error changes both the location and whether a repair happens. The bench models every FFT channel as a simple linear rotation. It computes the fault-free outputs itself, then adds a chosen offset to a single channel, either real or imaginary. This lets it place a difference at exactly `thr` and at `thr` plus one, and it also covers each of the seven channels and long runs of random single faults.

// File: rtl/hfg_pkg.sv
// Shared constants and code tables for the coded FFT correction stage.
// Assumes four original channels and three check channels.
package hfg_pkg;
    localparam int N_ORIG = 4;
    localparam int N_CHK  = 3;

    // Membership of each check group: bit m set means original channel m+1.
    function automatic logic [N_ORIG-1:0] grp_mask(input int k);
        case (k)
            0:       return 4'b0111;
            1:       return 4'b1011;
            default: return 4'b1101;
        endcase
    endfunction

    // Check used to rebuild original channel index m (0-based).
    function automatic int fix_chk(input int m);
        return (m == 3) ? 1 : 0;
    endfunction

    // Syndrome {C1,C2,C3} to 1-based channel number, 0 for no error.
    function automatic logic [2:0] loc_decode(input logic [2:0] syn);
        case (syn)
            3'b111:  return 3'd1;
            3'b110:  return 3'd2;
            3'b101:  return 3'd3;
            3'b011:  return 3'd4;
            3'b100:  return 3'd5;
            3'b010:  return 3'd6;
            3'b001:  return 3'd7;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/hfg_encoder.sv
// Forms the three check-channel input streams as group sums of the
// original inputs. Purely combinational; assumes RIN_W >= IN_W + 2.
module hfg_encoder #(
    parameter int IN_W  = 12,
    parameter int RIN_W = 14
) (
    input  logic [hfg_pkg::N_ORIG*IN_W-1:0] x,
    output logic [hfg_pkg::N_CHK*RIN_W-1:0] enc
);
    localparam int EXT = RIN_W - IN_W;

    for (genvar k = 0; k < hfg_pkg::N_CHK; k++) begin : g_grp
        localparam logic [hfg_pkg::N_ORIG-1:0] MASK = hfg_pkg::grp_mask(k);
        logic [RIN_W-1:0] acc;
        // Sum the sign-extended members of group k.
        always_comb begin
            acc = '0;
            for (int m = 0; m < hfg_pkg::N_ORIG; m++)
                if (MASK[m])
                    acc = acc + {{EXT{x[m*IN_W+IN_W-1]}}, x[m*IN_W +: IN_W]};
        end
        assign enc[k*RIN_W +: RIN_W] = acc;
    end
endmodule

// File: rtl/hfg_check.sv
// One parity check: flags when the check channel differs from the sum of
// its group by more than thr on either the real or the imaginary part.
// Assumes ROUT_W >= OUT_W + 2 so the group sum fits.
module hfg_check #(
    parameter int OUT_W  = 14,
    parameter int ROUT_W = 16,
    parameter int K      = 0
) (
    input  logic [hfg_pkg::N_ORIG*OUT_W-1:0] y_re,
    input  logic [hfg_pkg::N_ORIG*OUT_W-1:0] y_im,
    input  logic [ROUT_W-1:0]                r_re,
    input  logic [ROUT_W-1:0]                r_im,
    input  logic [ROUT_W-1:0]                thr,
    output logic                             flag
);
    localparam int DW = ROUT_W + 2;
    localparam logic [hfg_pkg::N_ORIG-1:0] MASK = hfg_pkg::grp_mask(K);

    // Absolute difference between check channel and group sum.
    function automatic logic [DW-1:0] gap(input logic [hfg_pkg::N_ORIG*OUT_W-1:0] y,
                                          input logic [ROUT_W-1:0] r);
        logic [DW-1:0] acc;
        logic [DW-1:0] d;
        acc = '0;
        for (int m = 0; m < hfg_pkg::N_ORIG; m++)
            if (MASK[m])
                acc = acc + {{(DW-OUT_W){y[m*OUT_W+OUT_W-1]}}, y[m*OUT_W +: OUT_W]};
        d = {{(DW-ROUT_W){r[ROUT_W-1]}}, r} - acc;
        return d[DW-1] ? (~d + 1'b1) : d;
    endfunction

    logic [DW-1:0] gap_re, gap_im;

    // Compare both parts against the zero-extended threshold.
    always_comb begin
        gap_re = gap(y_re, r_re);
        gap_im = gap(y_im, r_im);
        flag   = (gap_re > {2'b00, thr}) || (gap_im > {2'b00, thr});
    end
endmodule

// File: rtl/hfg_rebuild.sv
// Rebuilds original channel M (0-based) from its check channel minus the
// other members of that check's group. Assumes only channel M is faulty.
module hfg_rebuild #(
    parameter int OUT_W  = 14,
    parameter int ROUT_W = 16,
    parameter int M      = 0
) (
    input  logic [hfg_pkg::N_ORIG*OUT_W-1:0] y_re,
    input  logic [hfg_pkg::N_ORIG*OUT_W-1:0] y_im,
    input  logic [OUT_W-1:0]                 r_re,
    input  logic [OUT_W-1:0]                 r_im,
    output logic [OUT_W-1:0]                 fix_re,
    output logic [OUT_W-1:0]                 fix_im
);
    localparam int K = hfg_pkg::fix_chk(M);
    localparam logic [hfg_pkg::N_ORIG-1:0] MASK = hfg_pkg::grp_mask(K);

    // Subtract the healthy group members, modulo 2^OUT_W.
    function automatic logic [OUT_W-1:0] rebuild(input logic [hfg_pkg::N_ORIG*OUT_W-1:0] y,
                                                 input logic [OUT_W-1:0] r);
        logic [OUT_W-1:0] acc;
        acc = r;
        for (int m = 0; m < hfg_pkg::N_ORIG; m++)
            if (MASK[m] && (m != M))
                acc = acc - y[m*OUT_W +: OUT_W];
        return acc;
    endfunction

    // Rebuild both parts.
    always_comb begin
        fix_re = rebuild(y_re, r_re);
        fix_im = rebuild(y_im, r_im);
    end
endmodule

// File: rtl/hfg_guard.sv
// Coded correction stage for four parallel FFT channels. It encodes three
// check-channel inputs, checks the seven FFT outputs, decodes the faulty
// channel and replaces a faulty original output. Results are registered
// with one cycle of latency. Assumes at most one faulty channel per sample.
module hfg_guard #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 14,
    parameter int RIN_W  = 14,
    parameter int ROUT_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [hfg_pkg::N_ORIG*IN_W-1:0]     x_re,
    input  logic [hfg_pkg::N_ORIG*IN_W-1:0]     x_im,
    output logic [hfg_pkg::N_CHK*RIN_W-1:0]     enc_re,
    output logic [hfg_pkg::N_CHK*RIN_W-1:0]     enc_im,
    input  logic                                in_valid,
    input  logic [hfg_pkg::N_ORIG*OUT_W-1:0]    y_re,
    input  logic [hfg_pkg::N_ORIG*OUT_W-1:0]    y_im,
    input  logic [hfg_pkg::N_CHK*ROUT_W-1:0]    r_re,
    input  logic [hfg_pkg::N_CHK*ROUT_W-1:0]    r_im,
    input  logic [ROUT_W-1:0]                   thr,
    output logic                                out_valid,
    output logic [hfg_pkg::N_ORIG*OUT_W-1:0]    z_re,
    output logic [hfg_pkg::N_ORIG*OUT_W-1:0]    z_im,
    output logic [2:0]                          err_loc
);
    localparam int NO = hfg_pkg::N_ORIG;
    localparam int NC = hfg_pkg::N_CHK;

    hfg_encoder #(.IN_W(IN_W), .RIN_W(RIN_W)) u_enc_re (.x(x_re), .enc(enc_re));
    hfg_encoder #(.IN_W(IN_W), .RIN_W(RIN_W)) u_enc_im (.x(x_im), .enc(enc_im));

    logic [NC-1:0] syn;   // syn[2] = C1, syn[0] = C3
    for (genvar k = 0; k < NC; k++) begin : g_chk
        hfg_check #(.OUT_W(OUT_W), .ROUT_W(ROUT_W), .K(k)) u_chk (
            .y_re(y_re), .y_im(y_im),
            .r_re(r_re[k*ROUT_W +: ROUT_W]), .r_im(r_im[k*ROUT_W +: ROUT_W]),
            .thr(thr), .flag(syn[NC-1-k])
        );
    end

    logic [2:0] loc;
    assign loc = hfg_pkg::loc_decode(syn);

    logic [NO*OUT_W-1:0] z_re_nxt, z_im_nxt;
    for (genvar m = 0; m < NO; m++) begin : g_fix
        localparam int KF = hfg_pkg::fix_chk(m);
        logic [OUT_W-1:0] fr, fi;
        hfg_rebuild #(.OUT_W(OUT_W), .ROUT_W(ROUT_W), .M(m)) u_fix (
            .y_re(y_re), .y_im(y_im),
            .r_re(r_re[KF*ROUT_W +: OUT_W]), .r_im(r_im[KF*ROUT_W +: OUT_W]),
            .fix_re(fr), .fix_im(fi)
        );
        // Select the rebuilt value only for the located channel.
        always_comb begin
            if (loc == 3'(m + 1)) begin
                z_re_nxt[m*OUT_W +: OUT_W] = fr;
                z_im_nxt[m*OUT_W +: OUT_W] = fi;
            end else begin
                z_re_nxt[m*OUT_W +: OUT_W] = y_re[m*OUT_W +: OUT_W];
                z_im_nxt[m*OUT_W +: OUT_W] = y_im[m*OUT_W +: OUT_W];
            end
        end
    end

    // Output register with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            z_re      <= '0;
            z_im      <= '0;
            err_loc   <= 3'd0;
        end else begin
            out_valid <= in_valid;
            z_re      <= z_re_nxt;
            z_im      <= z_im_nxt;
            err_loc   <= in_valid ? loc : 3'd0;
        end
    end

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R8
    loc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (err_loc == 3'd0));

    // R6 R7
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (err_loc == 3'd0 || err_loc >= 3'd5))
        |-> (z_re == $past(y_re) && z_im == $past(y_im)));

    // R4
    grp1_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_loc >= 3'd1 && err_loc <= 3'd3)
        |-> (OUT_W'(z_re[0 +: OUT_W] + z_re[OUT_W +: OUT_W] + z_re[2*OUT_W +: OUT_W])
             == $past(r_re[0 +: OUT_W])));

    // R5
    grp2_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_loc == 3'd4)
        |-> (OUT_W'(z_im[0 +: OUT_W] + z_im[OUT_W +: OUT_W] + z_im[3*OUT_W +: OUT_W])
             == $past(r_im[ROUT_W +: OUT_W])));
endmodule

// File: tb/hfg_guard_tb.sv
// Scoreboard bench: the driver models the FFT channels as a linear rotation,
// injects one fault, and queues the expected result; a monitor compares.
module hfg_guard_tb_top;
    localparam int IN_W = 12, OUT_W = 14, RIN_W = 14, ROUT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4*IN_W-1:0]   x_re = '0, x_im = '0;
    logic [3*RIN_W-1:0]  enc_re, enc_im;
    logic                in_valid = 1'b0;
    logic [4*OUT_W-1:0]  y_re = '0, y_im = '0;
    logic [3*ROUT_W-1:0] r_re = '0, r_im = '0;
    logic [ROUT_W-1:0]   thr = 16'd20;
    logic                out_valid;
    logic [4*OUT_W-1:0]  z_re, z_im;
    logic [2:0]          err_loc;

    hfg_guard #(.IN_W(IN_W), .OUT_W(OUT_W), .RIN_W(RIN_W), .ROUT_W(ROUT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .x_re(x_re), .x_im(x_im),
        .enc_re(enc_re), .enc_im(enc_im), .in_valid(in_valid),
        .y_re(y_re), .y_im(y_im), .r_re(r_re), .r_im(r_im), .thr(thr),
        .out_valid(out_valid), .z_re(z_re), .z_im(z_im), .err_loc(err_loc)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct packed {
        logic [4*OUT_W-1:0] zr;
        logic [4*OUT_W-1:0] zi;
        logic [2:0]         loc;
    } exp_t;

    exp_t  q[$];
    string q_tag[$];
    int n_chk = 0, n_fail = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int grp(input int k, input int m);
        case (k)
            0: return (m == 0 || m == 1 || m == 2) ? 1 : 0;
            1: return (m == 0 || m == 1 || m == 3) ? 1 : 0;
            default: return (m == 0 || m == 2 || m == 3) ? 1 : 0;
        endcase
    endfunction

    function automatic int absv(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Driver: one sample, with fault (re/im offsets) on channel fm (1..7, 0 none).
    task automatic send(input int fm, input int f_re, input int f_im, input int t);
        int xr[4], xi[4], yr[4], yi[4], hr[4], hi[4], er[3], ei[3], rr[3], ri[3];
        int c[3];
        int code, loc;
        exp_t e;
        string tag;
        for (int m = 0; m < 4; m++) begin
            xr[m] = int'($urandom_range(2000)) - 1000;
            xi[m] = int'($urandom_range(2000)) - 1000;
            yr[m] = xr[m] - xi[m];
            yi[m] = xr[m] + xi[m];
            hr[m] = yr[m];
            hi[m] = yi[m];
        end
        for (int k = 0; k < 3; k++) begin
            er[k] = 0; ei[k] = 0;
            for (int m = 0; m < 4; m++) if (grp(k, m) == 1) begin
                er[k] += xr[m]; ei[k] += xi[m];
            end
            rr[k] = er[k] - ei[k];
            ri[k] = er[k] + ei[k];
        end
        if (fm >= 1 && fm <= 4) begin yr[fm-1] += f_re; yi[fm-1] += f_im; end
        if (fm >= 5) begin rr[fm-5] += f_re; ri[fm-5] += f_im; end
        @(negedge clk);
        thr = t[ROUT_W-1:0];
        for (int m = 0; m < 4; m++) begin
            x_re[m*IN_W +: IN_W] = xr[m][IN_W-1:0];
            x_im[m*IN_W +: IN_W] = xi[m][IN_W-1:0];
            y_re[m*OUT_W +: OUT_W] = yr[m][OUT_W-1:0];
            y_im[m*OUT_W +: OUT_W] = yi[m][OUT_W-1:0];
        end
        for (int k = 0; k < 3; k++) begin
            r_re[k*ROUT_W +: ROUT_W] = rr[k][ROUT_W-1:0];
            r_im[k*ROUT_W +: ROUT_W] = ri[k][ROUT_W-1:0];
        end
        in_valid = 1'b1;
        #1;
        for (int k = 0; k < 3; k++) begin
            // R1: encoder group sums
            check(int'($signed(enc_re[k*RIN_W +: RIN_W])) == er[k], "R1", "enc_re",
                  64'(enc_re[k*RIN_W +: RIN_W]), 64'(er[k][RIN_W-1:0]));
            check(int'($signed(enc_im[k*RIN_W +: RIN_W])) == ei[k], "R1", "enc_im",
                  64'(enc_im[k*RIN_W +: RIN_W]), 64'(ei[k][RIN_W-1:0]));
        end
        // R2: expected check bits, strictly greater than t
        for (int k = 0; k < 3; k++) begin
            int sr = 0, si = 0;
            for (int m = 0; m < 4; m++) if (grp(k, m) == 1) begin sr += yr[m]; si += yi[m]; end
            c[k] = (absv(rr[k] - sr) > t || absv(ri[k] - si) > t) ? 1 : 0;
        end
        code = c[0] * 4 + c[1] * 2 + c[2];
        // R3: decode table
        case (code)
            7: loc = 1; 6: loc = 2; 5: loc = 3; 3: loc = 4;
            4: loc = 5; 2: loc = 6; 1: loc = 7; default: loc = 0;
        endcase
        for (int m = 0; m < 4; m++) begin
            e.zr[m*OUT_W +: OUT_W] = yr[m][OUT_W-1:0];
            e.zi[m*OUT_W +: OUT_W] = yi[m][OUT_W-1:0];
        end
        if (loc >= 1 && loc <= 4) begin
            e.zr[(loc-1)*OUT_W +: OUT_W] = hr[loc-1][OUT_W-1:0];
            e.zi[(loc-1)*OUT_W +: OUT_W] = hi[loc-1][OUT_W-1:0];
        end
        e.loc = loc[2:0];
        if (loc == 0) tag = "R7/R2";
        else if (loc <= 3) tag = "R4/R3";
        else if (loc == 4) tag = "R5/R3";
        else tag = "R6/R3";
        q.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compares registered outputs one cycle after each sample (R8).
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", "unexpected out_valid", 64'(1), 64'(0));
                end else begin
                    exp_t e;
                    string tg;
                    e = q.pop_front();
                    tg = q_tag.pop_front();
                    check(err_loc == e.loc, tg, "err_loc", 64'(err_loc), 64'(e.loc));
                    check(z_re == e.zr, tg, "z_re", 64'(z_re), 64'(e.zr));
                    check(z_im == e.zi, tg, "z_im", 64'(z_im), 64'(e.zi));
                end
            end else begin
                check(err_loc == 3'd0, "R8", "err_loc while idle", 64'(err_loc), 64'(0));
                check(q.size() == 0, "R8", "missing out_valid", 64'(q.size()), 64'(0));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 64'(0), 64'(1));
        finish_run();
    end

    initial begin
        y_re = '1; y_im = '1; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset clears everything
        check(out_valid == 1'b0, "R9", "out_valid", 64'(out_valid), 64'(0));
        check(err_loc == 3'd0, "R9", "err_loc", 64'(err_loc), 64'(0));
        check(z_re == '0 && z_im == '0, "R9", "z", 64'(z_re), 64'(0));
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R7: clean samples
        for (int i = 0; i < 4; i++) send(0, 0, 0, 20);
        // R4: channels 1..3 rebuilt through check 1
        send(1, 500, 0, 20);
        send(2, 0, -300, 20);
        send(3, 77, 0, 20);
        // R5: channel 4 rebuilt through check 2
        send(4, 0, 900, 20);
        // R6: check-channel faults pass through
        send(5, 400, 0, 20);
        send(6, 0, -400, 20);
        send(7, 1000, 1000, 20);
        // R2: threshold boundaries, real and imaginary only
        send(2, 20, 0, 20);
        send(2, 21, 0, 20);
        send(4, 0, -20, 20);
        send(4, 0, -21, 20);
        send(6, 0, 21, 20);
        send(3, 0, 0, 0);
        // R8: gap with in_valid low
        idle(3);
        // Random single faults
        for (int i = 0; i < 40; i++) begin
            int fm, fr, fi;
            fm = int'($urandom_range(7));
            fr = int'($urandom_range(1200)) - 600;
            fi = int'($urandom_range(1200)) - 600;
            send(fm, fr, fi, int'($urandom_range(40)));
        end
        idle(4);
        finish_run();
    end
endmodule